// File: doc/BRIEF.md
# Northbound Read Frame Packer

This block sits in a memory buffer and sends return frames to the host. Each frame has a fixed length and is spread over a set of parallel bit lanes for a fixed number of bit times. A frame carries a 144-bit payload, which is either a read data word or a status word requested by a sync command. A CRC split into two halves follows the payload. There is no header. A frame with nothing to carry is an idle frame: its payload is zero and its CRC is deliberately inverted, so a receiver can discard it.

Read data comes in through a one-entry holding register with a valid/ready handshake. Frames begin only on frame boundaries, and the beat counter sets those boundaries. In failover mode one chosen lane is switched off and the second CRC half is not sent. The full payload still goes out in the same number of bit times. The lane outputs are plain per-cycle bits. The `frame_start_o` output marks beat 0 of every frame.

Top module: `nb_frame_packer`

## Requirements
- R1: A frame lasts 12 cycles on 14 lanes (168 bits). `frame_start_o` is high only on beat 0 of each frame, and a new frame begins every 12 cycles with no gap.
- R2: Normal mode maps frame bit i to lane i mod 14 at beat i div 14. Frame bits 0..143 are payload bits 0..143. Bits 144..155 are CRC half A bits 0..11. Bits 156..167 are CRC half B bits 0..11.
- R3: Each CRC half is a 12-bit register that starts at zero and takes the payload bits in order from bit 0 to bit 143. For each bit: fb = bit XOR crc[11], then crc = (crc << 1) XOR (fb ? poly : 0). Half A uses poly 12'h80F and half B uses poly 12'hB75.
- R4: A frame is idle when, at frame load, there is no pending sync and no held word. An idle frame has an all-zero payload and both CRC halves inverted, so bits 144..167 are all ones.
- R5: `data_ready_o` is high only while the holding register is empty. An accepted word goes out in the first frame loaded after its acceptance. Frames are loaded on the last beat of the previous frame. Ready stays low until that load, and words leave in the order they were accepted.
- R6: A `sync_i` pulse makes the next frame loaded a status frame. Its payload is `status_i` as sampled in the load cycle, with a valid CRC. A status frame takes priority over a held word, which goes out in the frame after it.
- R7: `failover_i` and `fail_lane_i` (0..13) are sampled only at frame load and hold for the whole frame. In failover mode the 13 active lanes are the physical lanes in ascending order with `fail_lane_i` skipped. Frame bit i goes to active lane i mod 13 at beat i div 13. Bits 0..155 are sent (payload plus CRC half A), CRC half B is not sent, and the disabled lane drives 0.
- R8: While reset is low, all lanes are 0, `frame_start_o` is 0 and `data_ready_o` is 1. The first frame is loaded on the first clock edge after release.
- R9: An idle frame in failover mode sends CRC half A inverted (all ones) after the zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-time clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_valid_i | input | 1 | Read data word is offered |
| data_i | input | 144 | Read data word |
| data_ready_o | output | 1 | Holding register is empty |
| sync_i | input | 1 | Sync command seen; request a status frame |
| status_i | input | 144 | Status word, sampled at frame load |
| failover_i | input | 1 | Use one-lane-removed mode from the next frame |
| fail_lane_i | input | 4 | Index of the lane to disable in failover |
| lane_o | output | 14 | Per-lane bit for the current beat |
| frame_start_o | output | 1 | High on beat 0 of every frame |

## Verification
The bench builds the packer with its default parameters: 14 lanes, 12 beats, a 144-bit payload and two 12-bit CRC halves. Under these values the normal mode fills all 168 bit positions exactly and the failover mode fills exactly 156, so a reassembled frame tests every mapping position and the CRC boundary. Disabling lane 0 and lane 13 tests both ends of the skip logic. Holding data back against a sync request tests the frame-boundary ordering that the one-entry register and the priority rule define.

// File: rtl/nb_pkg.sv
package nb_pkg;
  typedef enum logic [1:0] {
    FK_IDLE   = 2'd0,
    FK_DATA   = 2'd1,
    FK_STATUS = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/nb_crc12.sv
module nb_crc12 #(
  parameter int          DATA_W = 144,
  parameter int          CRC_W  = 12,
  parameter logic [11:0] POLY   = 12'h80F
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] c;

  // serial shift unrolled over the payload, bit 0 first
  always_comb begin
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c = {c[CRC_W-2:0], 1'b0} ^ ((data_i[i] ^ c[CRC_W-1]) ? POLY[CRC_W-1:0] : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/nb_ingress.sv
module nb_ingress #(
  parameter int DATA_W = 144
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              ready_o,
  output logic              full_o,
  output logic [DATA_W-1:0] word_o
);
  logic              full_q;
  logic [DATA_W-1:0] hold_q;
  logic              accept;

  assign accept  = valid_i & ~full_q;
  assign ready_o = ~full_q;
  assign full_o  = full_q;
  assign word_o  = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        hold_q <= data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !take_i |=> full_q && $stable(hold_q)); // R5

  AST_NO_TAKE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q); // R5
endmodule

// File: rtl/nb_lane_map.sv
module nb_lane_map #(
  parameter int LANES = 14,
  parameter int BEATS = 12,
  localparam int FRAME_W   = LANES * BEATS,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int BEAT_BITS = $clog2(BEATS),
  localparam int IDX_W     = $clog2(FRAME_W)
) (
  input  logic [FRAME_W-1:0]   frame_i,
  input  logic [BEAT_BITS-1:0] beat_i,
  input  logic                 fo_i,
  input  logic [LANE_BITS-1:0] dead_i,
  output logic [LANES-1:0]     lane_o
);
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic             off;

    // inverse map: physical lane -> frame bit index
    always_comb begin
      off = 1'b0;
      if (fo_i) begin
        if (dead_i == LANE_BITS'(p)) begin
          off = 1'b1;
          idx = '0;
        end else if (LANE_BITS'(p) < dead_i) begin
          idx = IDX_W'(int'(beat_i) * (LANES - 1) + p);
        end else begin
          idx = IDX_W'(int'(beat_i) * (LANES - 1) + p - 1);
        end
      end else begin
        idx = IDX_W'(int'(beat_i) * LANES + p);
      end
    end

    assign lane_o[p] = off ? 1'b0 : frame_i[idx];
  end
endmodule

// File: rtl/nb_frame_packer.sv
module nb_frame_packer #(
  parameter int          LANES  = 14,
  parameter int          BEATS  = 12,
  parameter int          DATA_W = 144,
  parameter int          CRC_W  = 12,
  parameter logic [11:0] POLY_A = 12'h80F,
  parameter logic [11:0] POLY_B = 12'hB75,
  localparam int FRAME_W   = LANES * BEATS,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int BEAT_BITS = $clog2(BEATS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 data_valid_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic                 data_ready_o,
  input  logic                 sync_i,
  input  logic [DATA_W-1:0]    status_i,
  input  logic                 failover_i,
  input  logic [LANE_BITS-1:0] fail_lane_i,
  output logic [LANES-1:0]     lane_o,
  output logic                 frame_start_o
);
  import nb_pkg::*;

  localparam logic [1:0][11:0] POLYS = {POLY_B, POLY_A};

  logic [BEAT_BITS-1:0] beat_q;
  logic [FRAME_W-1:0]   frame_q, frame_d;
  logic                 fo_q;
  logic [LANE_BITS-1:0] dead_q;
  logic                 sync_pend_q;
  logic                 load, take, hold_full;
  logic [DATA_W-1:0]    hold_word, payload;
  logic [1:0][CRC_W-1:0] crc;
  frame_kind_e          kind;

  assign load = (beat_q == BEAT_BITS'(BEATS - 1));

  nb_ingress #(.DATA_W(DATA_W)) u_ingress (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (data_valid_i),
    .data_i  (data_i),
    .take_i  (take),
    .ready_o (data_ready_o),
    .full_o  (hold_full),
    .word_o  (hold_word)
  );

  // status beats held data, held data beats idle
  always_comb begin
    if (sync_pend_q)    kind = FK_STATUS;
    else if (hold_full) kind = FK_DATA;
    else                kind = FK_IDLE;
    case (kind)
      FK_STATUS: payload = status_i;
      FK_DATA:   payload = hold_word;
      default:   payload = '0;
    endcase
  end

  assign take = load && (kind == FK_DATA);

  for (genvar h = 0; h < 2; h++) begin : g_crc
    nb_crc12 #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLYS[h])) u_crc (
      .data_i (payload),
      .crc_o  (crc[h])
    );
  end

  // idle frames: correct CRC with every bit flipped
  assign frame_d = {crc[1] ^ {CRC_W{kind == FK_IDLE}},
                    crc[0] ^ {CRC_W{kind == FK_IDLE}},
                    payload};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q      <= BEAT_BITS'(BEATS - 1);
      frame_q     <= '0;
      fo_q        <= 1'b0;
      dead_q      <= '0;
      sync_pend_q <= 1'b0;
    end else begin
      sync_pend_q <= sync_i | (sync_pend_q & ~load);
      if (load) begin
        beat_q  <= '0;
        frame_q <= frame_d;
        fo_q    <= failover_i;
        dead_q  <= fail_lane_i;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  nb_lane_map #(.LANES(LANES), .BEATS(BEATS)) u_map (
    .frame_i (frame_q),
    .beat_i  (beat_q),
    .fo_i    (fo_q),
    .dead_i  (dead_q),
    .lane_o  (lane_o)
  );

  assign frame_start_o = (beat_q == '0);

  AST_FRAME_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> $past(beat_q) == BEAT_BITS'(BEATS - 1)); // R1

  AST_DEAD_LANE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fo_q && (int'(dead_q) < LANES) |-> !lane_o[dead_q]); // R7

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(fo_q) && $stable(dead_q)); // R7

  AST_SYNC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && sync_pend_q |=> frame_q[DATA_W-1:0] == $past(status_i) && !data_ready_o == $past(hold_full)); // R6

  AST_IDLE_CRC_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && !sync_pend_q && data_ready_o |=> frame_q[DATA_W-1:0] == '0 && &frame_q[FRAME_W-1:DATA_W]); // R4

  AST_READY_FREED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && !sync_pend_q && !data_ready_o |=> data_ready_o); // R5
endmodule

// File: tb/nb_frame_packer_tb.sv
module nb_frame_packer_tb;
  localparam int L  = 14;
  localparam int B  = 12;
  localparam int DW = 144;
  localparam int FW = L * B;
  localparam logic [11:0] PA = 12'h80F;
  localparam logic [11:0] PB = 12'hB75;

  // {kind[1:0] (0 idle,1 data,2 status), failover, fail_lane[3:0], seed[31:0]}
  localparam logic [38:0] VEC [8] = '{
    {2'd1, 1'b0, 4'd0,  32'h1234_5678},
    {2'd0, 1'b0, 4'd0,  32'h0000_0000},
    {2'd2, 1'b0, 4'd0,  32'hA5A5_0F0F},
    {2'd1, 1'b1, 4'd0,  32'hDEAD_BEEF},
    {2'd1, 1'b1, 4'd13, 32'h0000_0001},
    {2'd0, 1'b1, 4'd6,  32'h0000_0000},
    {2'd2, 1'b1, 4'd9,  32'hFFFF_FFFF},
    {2'd1, 1'b0, 4'd0,  32'h0000_0000}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          data_valid_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          data_ready_o;
  logic          sync_i = 1'b0;
  logic [DW-1:0] status_i = '0;
  logic          failover_i = 1'b0;
  logic [3:0]    fail_lane_i = '0;
  logic [L-1:0]  lane_o;
  logic          frame_start_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  nb_frame_packer u_dut (
    .clk_i, .rst_ni, .data_valid_i, .data_i, .data_ready_o, .sync_i,
    .status_i, .failover_i, .fail_lane_i, .lane_o, .frame_start_o
  );

  function automatic logic [11:0] crc12(input logic [DW-1:0] d, input logic [11:0] poly);
    logic [11:0] c = '0;
    for (int i = 0; i < DW; i++) begin
      logic fb;
      fb = d[i] ^ c[11];
      c = {c[10:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  function automatic logic [DW-1:0] mk(input logic [31:0] s);
    return {s[15:0], s, ~s, s ^ 32'h5A5A_C3C3, {s[7:0], s[31:8]}};
  endfunction

  function automatic logic [FW-1:0] exp_frame(input logic [DW-1:0] p, input logic idle);
    logic [DW-1:0] q;
    logic [11:0] a, b;
    q = idle ? '0 : p;
    a = crc12(q, PA);
    b = crc12(q, PB);
    if (idle) begin a = ~a; b = ~b; end
    return {b, a, q};
  endfunction

  // forward map: frame bit -> (beat, lane); result indexed beat*L + lane
  function automatic logic [FW-1:0] exp_lanes(input logic [FW-1:0] f, input logic fo, input int fl);
    logic [FW-1:0] m = '0;
    for (int i = 0; i < FW; i++) begin
      int k, bt, p;
      if (fo) begin
        if (i < DW + 12) begin
          k = i % (L - 1);
          bt = i / (L - 1);
          p = (k < fl) ? k : k + 1;
          m[bt * L + p] = f[i];
        end
      end else begin
        m[(i / L) * L + (i % L)] = f[i];
      end
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // waits for beat 0, then samples 12 beats; returns on the beat 11 negedge
  task automatic capture(output logic [FW-1:0] m);
    m = '0;
    while (!frame_start_o) @(negedge clk_i);
    for (int b = 0; b < B; b++) begin
      m[b * L +: L] = lane_o;
      if (b < B - 1) @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [FW-1:0] cap, cap2;
    logic [DW-1:0] w1, w2;

    // R8 reset state
    repeat (3) @(negedge clk_i);
    chk("R8 lanes in reset", FW'(lane_o), '0);
    chk("R8 ready in reset", FW'(data_ready_o), FW'(1));
    chk("R8 frame_start in reset", FW'(frame_start_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 R1 first frame after release", FW'(frame_start_o), FW'(1));

    // table: drive at beat 0 of frame N, capture frame N+1
    for (int v = 0; v < 8; v++) begin
      logic [1:0]    kd;
      logic          fo;
      logic [3:0]    fl;
      logic [DW-1:0] w;
      logic [FW-1:0] ef;
      kd = VEC[v][38:37];
      fo = VEC[v][36];
      fl = VEC[v][35:32];
      w  = mk(VEC[v][31:0]);
      while (!frame_start_o) @(negedge clk_i);
      failover_i  = fo;
      fail_lane_i = fl;
      if (kd == 2'd1) begin data_valid_i = 1'b1; data_i = w; end
      if (kd == 2'd2) begin sync_i = 1'b1; status_i = w; end
      @(negedge clk_i);
      data_valid_i = 1'b0;
      sync_i = 1'b0;
      capture(cap);
      ef = exp_frame(w, kd == 2'd0);
      case (kd)
        2'd0: chk(fo ? "R9 R4 idle failover" : "R4 idle normal", cap, exp_lanes(ef, fo, int'(fl)));
        2'd1: chk(fo ? "R7 R3 data failover" : "R2 R3 data normal", cap, exp_lanes(ef, fo, int'(fl)));
        default: chk(fo ? "R6 R7 status failover" : "R6 status normal", cap, exp_lanes(ef, fo, int'(fl)));
      endcase
    end

    // back to normal mode, let one frame drain
    while (!frame_start_o) @(negedge clk_i);
    failover_i = 1'b0;
    @(negedge clk_i);
    capture(cap);

    // R5 backpressure and ordering
    w1 = mk(32'hCAFE_0001);
    w2 = mk(32'h0BAD_F00D);
    while (!frame_start_o) @(negedge clk_i);
    data_valid_i = 1'b1;
    data_i = w1;
    @(negedge clk_i);
    data_i = w2;
    chk("R5 ready low while held", FW'(data_ready_o), '0);
    while (!data_ready_o) @(negedge clk_i);
    fork
      capture(cap);
      begin @(negedge clk_i); data_valid_i = 1'b0; end
    join
    chk("R5 first word next frame", cap, exp_lanes(exp_frame(w1, 1'b0), 1'b0, 0));
    capture(cap2);
    chk("R5 second word in order", cap2, exp_lanes(exp_frame(w2, 1'b0), 1'b0, 0));

    // R6 sync beats held data
    w1 = mk(32'h7777_1111);
    w2 = mk(32'h3C3C_9999);
    while (!frame_start_o) @(negedge clk_i);
    data_valid_i = 1'b1;
    data_i = w1;
    sync_i = 1'b1;
    status_i = w2;
    @(negedge clk_i);
    data_valid_i = 1'b0;
    sync_i = 1'b0;
    capture(cap);
    chk("R6 status first", cap, exp_lanes(exp_frame(w2, 1'b0), 1'b0, 0));
    capture(cap2);
    chk("R6 held data after status", cap2, exp_lanes(exp_frame(w1, 1'b0), 1'b0, 0));

    // R7 mid-frame mode change ignored by the running frame
    while (!frame_start_o) @(negedge clk_i);
    @(negedge clk_i);
    while (!frame_start_o) @(negedge clk_i);
    fork
      capture(cap);
      begin
        repeat (5) @(negedge clk_i);
        failover_i = 1'b1;
        fail_lane_i = 4'd3;
        repeat (4) @(negedge clk_i);
        failover_i = 1'b0;
      end
    join
    chk("R7 mode held within frame", cap, exp_lanes(exp_frame('0, 1'b1), 1'b0, 0));

    summary();
    $finish;
  end
endmodule